// File: doc/BRIEF.md
# Word-Split Register Access Port

This block is a synchronous slave that gives a 16-bit local bus access to a bank of 32-bit registers. Every register is reached as two 16-bit halves. A half-select line picks the half for each access. Two active-low byte enables pick which bytes of the 16-bit bus take part. A full 32-bit value can therefore be built up over several cycles, one byte or one half at a time.

Reads are pipelined. A read request sampled on one clock edge puts its data on the bus after that edge, and the data stays there until the next edge. Back-to-back requests give a continuous stream with one cycle of latency. Each byte lane has its own output enable. The bus pads outside the block use these enables to leave a lane undriven when its byte was not requested. The exception is the data-port register at a fixed address, which always drives both lanes. Contents have no side effects beyond storage.

Top module: `wsplit_reg_port`

## Requirements
- R1: After the asynchronous active-low reset, every register reads as zero and both lane output enables are 0.
- R2: The 5-bit address picks one 32-bit register (DWORD index). A write to one address leaves every other register unchanged.
- R3: With `half_n` low an access targets bits 15:0 of the register. With `half_n` high it targets bits 31:16.
- R4: `be_n[0]` low enables bus bits 7:0 and `be_n[1]` low enables bus bits 15:8. A write updates only the enabled bytes of the selected half. Writes in consecutive cycles to different bytes of one register accumulate.
- R5: A read sampled with `sel_n` and `rd_n` low at edge k presents the addressed half on `dq_o` after edge k, until edge k+1. Back-to-back reads each return their own data.
- R6: During a read data phase, `dq_oe[0]` (lane 7:0) and `dq_oe[1]` (lane 15:8) equal the inverted byte enables of the request cycle.
- R7: When the read address equals `PORT_ADDR` (default 0), both output enables are 1 whatever the byte enables were.
- R8: After an edge at which no read is sampled, both output enables are 0.
- R9: No register changes at an edge where `sel_n` is high, even with `wr_n` low.
- R10: If write and read are both asserted in a selected cycle, the write is performed and no data phase follows (enables stay 0).
- R11: The address, half-select and byte enables captured with a read request control its data phase. Input changes in the data-phase cycle do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low port select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 5 | DWORD register index |
| half_n | input | 1 | Half select: low = bits 15:0, high = bits 31:16 |
| be_n | input | 2 | Active-low byte enables for the two bus lanes |
| dq_i | input | 16 | Write data from the bus |
| dq_o | output | 16 | Read data to the bus |
| dq_oe | output | 2 | Per-lane output enables for `dq_o` |

## Verification
Two functions can meet in one cycle. A byte-masked write can fall on the same selected edge as a read request. A new read request can also fall in the data-phase cycle of the previous read. The bench provokes the first with cycles that hold write and read low together. It expects the reference image to take the write and the enables to stay off. It provokes the second with back-to-back reads of both halves at varied addresses and byte enables. In each data phase, the driven lanes and data must match the earlier request and not the inputs on the bus at that moment.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned LANES  = HALF_W / 8;
  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned BYTES  = WORD_W / 8;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic             upper;
    logic [LANES-1:0] lane_en;
    logic             port_hit;
  } req_t;
endpackage

// File: rtl/wsp_rst_sync.sv
module wsp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wsp_decode.sv
module wsp_decode
  import wsp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned PORT_ADDR = 0
) (
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              half_n,
  input  logic [LANES-1:0]  be_n,
  input  logic [ADDR_W-1:0] addr,
  output req_t              req
);
  localparam logic [ADDR_W-1:0] PORT_IDX = ADDR_W'(PORT_ADDR);

  always_comb begin
    req.wr       = !sel_n && !wr_n;
    req.rd       = !sel_n && !rd_n && wr_n;   // write wins over read
    req.upper    = half_n;
    req.lane_en  = ~be_n;
    req.port_hit = (addr == PORT_IDX);
  end
endmodule

// File: rtl/wsp_regbank.sv
module wsp_regbank
  import wsp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned NUM_REGS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  req_t              req,
  input  logic [ADDR_W-1:0] addr,
  input  half_t             wdata,
  output half_t             rd_word
);
  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;
  logic [NUM_REGS-1:0][BYTES-1:0]  wen;
  word_t                           sel_word;

  // per-register, per-byte write enables
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    for (genvar k = 0; k < BYTES; k++) begin : g_byte
      localparam bit HI_HALF = (k / LANES) == 1;
      localparam int LANE    = k % LANES;
      assign wen[g][k] = req.wr && (addr == ADDR_W'(g)) &&
                         (req.upper == HI_HALF) && req.lane_en[LANE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int g = 0; g < NUM_REGS; g++) begin
        for (int k = 0; k < BYTES; k++) begin
          if (wen[g][k]) regs_q[g][k*8 +: 8] <= wdata[(k % LANES)*8 +: 8];
        end
      end
    end
  end

  if (NUM_REGS == (1 << ADDR_W)) begin : g_full_map
    assign sel_word = regs_q[addr];
  end else begin : g_part_map
    always_comb begin
      sel_word = '0;
      for (int g = 0; g < NUM_REGS; g++)
        if (addr == ADDR_W'(g)) sel_word = regs_q[g];
    end
  end

  assign rd_word = req.upper ? sel_word[WORD_W-1:HALF_W] : sel_word[HALF_W-1:0];

  // R9: storage only moves on a decoded write
  assert_hold_unselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req.wr |=> $stable(regs_q));
endmodule

// File: rtl/wsp_rdpipe.sv
module wsp_rdpipe
  import wsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  req_t             req,
  input  half_t            rd_word,
  output half_t            dq_o,
  output logic [LANES-1:0] dq_oe
);
  half_t            data_d, data_q;
  logic [LANES-1:0] oe_d, oe_q;

  always_comb begin
    oe_d   = '0;
    data_d = data_q;
    if (req.rd) begin
      oe_d   = req.port_hit ? '1 : req.lane_en;
      data_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= '0;
      data_q <= '0;
    end else begin
      oe_q   <= oe_d;
      data_q <= data_d;
    end
  end

  assign dq_o  = data_q;
  assign dq_oe = oe_q;

  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req.rd |=> dq_o == $past(rd_word));
  assert_lane_follows_be_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req.rd && !req.port_hit) |=> dq_oe == $past(req.lane_en));
  assert_port_full_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req.rd && req.port_hit) |=> dq_oe == '1);
  assert_release_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req.rd |=> dq_oe == '0);
endmodule

// File: rtl/wsplit_reg_port.sv
module wsplit_reg_port
  import wsp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned PORT_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              half_n,
  input  logic [1:0]        be_n,
  input  logic [15:0]       dq_i,
  output logic [15:0]       dq_o,
  output logic [1:0]        dq_oe
);
  logic  rst_sync_n;
  req_t  req;
  half_t rd_word;

  wsp_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wsp_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) i_decode (
    .sel_n  (sel_n),
    .wr_n   (wr_n),
    .rd_n   (rd_n),
    .half_n (half_n),
    .be_n   (be_n),
    .addr   (addr),
    .req    (req)
  );

  wsp_regbank #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) i_regbank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (req),
    .addr    (addr),
    .wdata   (dq_i),
    .rd_word (rd_word)
  );

  wsp_rdpipe i_rdpipe (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (req),
    .rd_word (rd_word),
    .dq_o    (dq_o),
    .dq_oe   (dq_oe)
  );

  // R10: a combined write+read request never opens a data phase
  assert_write_beats_read_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sel_n && !wr_n && !rd_n) |=> dq_oe == 2'b00);
endmodule

// File: tb/test_wsplit_reg_port.sv
module test_wsplit_reg_port;
  localparam int PORT = 0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_n, wr_n, rd_n, half_n;
  logic [4:0]  addr;
  logic [1:0]  be_n;
  logic [15:0] dq_i, dq_o;
  logic [1:0]  dq_oe;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [31:0] model [32];

  always #2 clk = ~clk;

  wsplit_reg_port i_wsplit_reg_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .half_n(half_n), .be_n(be_n), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at the falling edge, judge the data phase after the rising edge
  task automatic step(input bit s_n, input bit w_n, input bit r_n, input logic [4:0] a,
                      input bit h_n, input logic [1:0] b_n, input logic [15:0] d,
                      input string tag);
    bit          is_rd, is_wr;
    logic [1:0]  exp_oe;
    logic [15:0] exp_d, mask;
    sel_n = s_n; wr_n = w_n; rd_n = r_n; addr = a; half_n = h_n; be_n = b_n; dq_i = d;
    is_wr  = !s_n && !w_n;
    is_rd  = !s_n && !r_n && w_n;
    exp_oe = !is_rd ? 2'b00 : (a == 5'(PORT)) ? 2'b11 : ~b_n;
    exp_d  = h_n ? model[a][31:16] : model[a][15:0];
    @(posedge clk);
    #1;
    if (!is_rd) check("R8 lanes released", {30'd0, dq_oe}, {30'd0, exp_oe});
    else if (a == 5'(PORT)) check("R7 port drives both lanes", {30'd0, dq_oe}, {30'd0, exp_oe});
    else check("R6 lane enables", {30'd0, dq_oe}, {30'd0, exp_oe});
    if (is_rd) begin
      mask = {{8{exp_oe[1]}}, {8{exp_oe[0]}}};
      check(tag, {16'd0, dq_o & mask}, {16'd0, exp_d & mask});
    end
    if (is_wr) begin
      if (!b_n[0]) model[a][(h_n ? 16 : 0) +: 8] = d[7:0];
      if (!b_n[1]) model[a][(h_n ? 24 : 8) +: 8] = d[15:8];
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] pattern(input int a);
    return (32'(a) + 32'd1) * 32'h0F1E_2D3B ^ 32'hA5C3_0000;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    rst_n = 1'b0; sel_n = 1; wr_n = 1; rd_n = 1; addr = '0; half_n = 0; be_n = '1; dq_i = '0;
    repeat (3) @(negedge clk);
    check("R1 enables off in reset", {30'd0, dq_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: every half reads zero, full lanes
    for (int a = 0; a < 32; a++) begin
      step(0, 1, 0, 5'(a), 0, 2'b00, 16'hDEAD, "R1 reset value low half");
      step(0, 1, 0, 5'(a), 1, 2'b00, 16'hBEEF, "R1 reset value high half");
    end
    step(1, 1, 1, 5'd3, 0, 2'b00, 16'h0, "R8 idle");

    // R2/R3/R4: build each register from a full low half and two single-byte high writes
    for (int a = 0; a < 32; a++) begin
      logic [31:0] v;
      v = pattern(a);
      step(0, 0, 1, 5'(a), 0, 2'b00, v[15:0], "R3 low half write");
      step(0, 0, 1, 5'(a), 1, 2'b10, {8'hEE, v[23:16]}, "R4 lane0 only");
      step(0, 0, 1, 5'(a), 1, 2'b01, {v[31:24], 8'h11}, "R4 lane1 only");
      if (a % 2 == 1) step(1, 0, 1, 5'(a), a[1], 2'b00, 16'h5A5A, "R9 unselected write");
      if (a % 4 == 2) step(0, 0, 0, 5'(a), 0, 2'b10, {8'h77, v[7:0] ^ 8'hFF}, "R10 write+read");
    end

    // R2/R5/R11: back-to-back reads of both halves with varied enables
    for (int a = 0; a < 32; a++) begin
      logic [1:0] b;
      b = 2'(a);
      step(0, 1, 0, 5'(a), 1, b,  16'hC0DE, "R5 high half data");
      step(0, 1, 0, 5'(a), 0, ~b, 16'hF00D, "R11 low half data");
      if (a % 3 == 0) step(1, 1, 0, 5'(31 - a), 1, 2'b00, 16'h0, "R8 idle read strobe");
    end

    // R7: data-port address with both lanes disabled still drives all bits
    step(0, 1, 0, 5'(PORT), 1, 2'b11, 16'h0, "R7 port data high");
    step(0, 1, 0, 5'(PORT), 0, 2'b11, 16'h0, "R7 port data low");
    step(0, 1, 0, 5'd9, 0, 2'b11, 16'h0, "R6 no lanes");
    step(1, 1, 1, 5'd9, 0, 2'b00, 16'h0, "R8 final idle");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule